// File: doc/BRIEF.md
# Shift-Add Fixed-Point Constant Multiplier

This block scales a signed 28-bit fixed-point sample by a constant chosen when the design is elaborated. It contains no multiplier. The product is built from a signed-digit sum of left-shifted copies of the input. For constants whose binary expansion repeats, a short chain of "add a right-shifted copy of yourself" stages extends the repeating pattern. All of this is computed in a wide accumulator that carries guard bits below the output LSB. A single slice of the accumulator then applies the final scaling, a truncation toward minus infinity and the two's-complement wrap together. The result passes through one register before it reaches the output.

Three constants are supported, selected by the `COEF` parameter. The first is 0.7, the default, for damping-style coefficients. The second is 0.01, for small step sizes. The third is the integer 5, which serves as an exact check case built as four times the input plus the input. Input and output share one format: a sign bit, three integer bits and twenty-four fraction bits. The output code is therefore the constant times the input code, and the binary point never moves.

Top module: `scm_const_mult`

## Requirements
- R1: `x_in` and `y_out` are 28-bit two's-complement codes in the same format (1 sign, 3 integer, 24 fraction bits), so the ideal output code is the constant multiplied by the input code.
- R2: `y_out` shows the result for the `x_in` value sampled at the previous rising edge of `clk`, and holds it until the next rising edge.
- R3: While `rst` is high at a rising edge, `y_out` becomes zero on that edge.
- R4: With `COEF` set to `COEF_0P7` (the default), `y_out` lies within 8 LSB of 0.7 times the input code, for every input code.
- R5: With `COEF` set to `COEF_0P01`, `y_out` lies within 8 LSB of 0.01 times the input code, for every input code.
- R6: With `COEF` set to `COEF_X5`, `y_out` equals 5 times the input code, reduced modulo 2^28. For example, the input 0x7FFFFFF gives 0x7FFFFFB, and the input 0x8000000 gives 0x8000000.
- R7: An input code of zero yields an output of zero for every constant.
- R8: For the fractional constants, the result is rounded toward minus infinity. It is never above the exact product, and it is less than 2 LSB below it.
- R9: For the fractional constants, the sign bit of `y_out` equals the sign bit of the input that produced it. No input wraps, including 0x7FFFFFF and 0x8000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the output register loads on the rising edge |
| rst | input | 1 | Synchronous active-high reset that clears the output register |
| x_in | input | 28 | Signed Q3.24 operand |
| y_out | output | 28 | Signed Q3.24 product, registered |

## Verification
The only state in this block is the output register, so a wrong internal term appears at `y_out` exactly one cycle after the input that exposes it. Such faults include a flipped digit sign, a missing repeat stage or a misaligned output slice. Errors in the shift network grow with the operand's magnitude, so full-scale positive and negative inputs turn a small coefficient error into hundreds of LSB. Inputs whose exact product is an integer expose a rounding direction that is off by one. The integer constant has no tolerance at all, so any fault in the term sum or in the wrap shows as a bit mismatch.

// File: rtl/scm_pkg.sv
package scm_pkg;

    localparam int Q_W        = 28;
    localparam int MAX_TERMS  = 8;
    localparam int MAX_REP    = 4;
    localparam int GUARD_DEF  = 8;
    localparam int HEAD_DEF   = 24;

    typedef enum logic [1:0] {
        COEF_0P7  = 2'd0,
        COEF_0P01 = 2'd1,
        COEF_X5   = 2'd2
    } coef_e;

    // One signed digit: add or subtract the operand shifted left by lsh.
    typedef struct packed {
        logic       neg;
        logic [5:0] lsh;
    } term_t;

    // Integer numerator K of the constant, written as signed digits.
    // 0.7  : K = 21    = 16 + 4 + 1
    // 0.01 : K = 41943 = 2^15 + 2^13 + 2^10 - 2^6 + 2^4 + 2^3 - 2^0
    // 5    : K = 5     = 4 + 1
    function automatic int n_terms(coef_e c);
        case (c)
            COEF_0P7:  return 3;
            COEF_0P01: return 7;
            default:   return 2;
        endcase
    endfunction

    function automatic term_t term_at(coef_e c, int i);
        term_t t;
        t = '{neg: 1'b0, lsh: 6'd0};
        case (c)
            COEF_0P7: begin
                case (i)
                    0: t.lsh = 6'd4;
                    1: t.lsh = 6'd2;
                    default: t.lsh = 6'd0;
                endcase
            end
            COEF_0P01: begin
                case (i)
                    0: t.lsh = 6'd15;
                    1: t.lsh = 6'd13;
                    2: t.lsh = 6'd10;
                    3: begin t.lsh = 6'd6; t.neg = 1'b1; end
                    4: t.lsh = 6'd4;
                    5: t.lsh = 6'd3;
                    6: begin t.lsh = 6'd0; t.neg = 1'b1; end
                    default: t.lsh = 6'd0;
                endcase
            end
            default: begin
                case (i)
                    0: t.lsh = 6'd2;
                    default: t.lsh = 6'd0;
                endcase
            end
        endcase
        return t;
    endfunction

    // Power-of-two denominator applied after the digit sum.
    function automatic int frac_shift(coef_e c);
        case (c)
            COEF_0P7:  return 5;
            COEF_0P01: return 22;
            default:   return 0;
        endcase
    endfunction

    // Repeating expansion: multiply by (1 + 2^-P)(1 + 2^-2P)... for n stages,
    // which approximates 1 / (1 - 2^-P).
    function automatic int rep_base(coef_e c);
        case (c)
            COEF_0P7:  return 4;
            COEF_0P01: return 20;
            default:   return 0;
        endcase
    endfunction

    function automatic int rep_count(coef_e c);
        case (c)
            COEF_0P7:  return 3;
            COEF_0P01: return 1;
            default:   return 0;
        endcase
    endfunction

endpackage

// File: rtl/scm_term_sum.sv
module scm_term_sum #(
    parameter scm_pkg::coef_e COEF    = scm_pkg::COEF_0P7,
    parameter int             DATA_W  = 28,
    parameter int             SUM_W   = 60,
    parameter int             GUARD_W = 8
) (
    input  logic [DATA_W-1:0]        din,
    output logic signed [SUM_W-1:0]  sum
);

    localparam int NT = scm_pkg::n_terms(COEF);

    logic signed [SUM_W-1:0] base;
    logic signed [SUM_W-1:0] part [scm_pkg::MAX_TERMS+1];

    // Sign-extend and move the operand above the guard bits.
    assign base    = {{(SUM_W-DATA_W){din[DATA_W-1]}}, din} <<< GUARD_W;
    assign part[0] = '0;

    for (genvar i = 0; i < scm_pkg::MAX_TERMS; i++) begin : g_term
        localparam scm_pkg::term_t T = scm_pkg::term_at(COEF, i);
        if (i >= NT) begin : g_pass
            assign part[i+1] = part[i];
        end else if (T.neg) begin : g_sub
            assign part[i+1] = part[i] - (base <<< T.lsh);
        end else begin : g_add
            assign part[i+1] = part[i] + (base <<< T.lsh);
        end
    end

    assign sum = part[scm_pkg::MAX_TERMS];

endmodule

// File: rtl/scm_repeat_chain.sv
module scm_repeat_chain #(
    parameter scm_pkg::coef_e COEF  = scm_pkg::COEF_0P7,
    parameter int             SUM_W = 60
) (
    input  logic signed [SUM_W-1:0] acc_in,
    output logic signed [SUM_W-1:0] acc_out
);

    localparam int NR = scm_pkg::rep_count(COEF);
    localparam int PB = scm_pkg::rep_base(COEF);

    logic signed [SUM_W-1:0] stg [scm_pkg::MAX_REP+1];

    assign stg[0] = acc_in;

    for (genvar j = 0; j < scm_pkg::MAX_REP; j++) begin : g_rep
        if (j < NR) begin : g_on
            localparam int SH = PB << j;
            // Arithmetic shift keeps the sign; dropped bits fall in guard range.
            assign stg[j+1] = stg[j] + (stg[j] >>> SH);
        end else begin : g_off
            assign stg[j+1] = stg[j];
        end
    end

    assign acc_out = stg[scm_pkg::MAX_REP];

endmodule

// File: rtl/scm_out_reg.sv
module scm_out_reg #(
    parameter int DATA_W = 28,
    parameter int SUM_W  = 60,
    parameter int DROP_W = 13
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [SUM_W-1:0] acc,
    output logic [DATA_W-1:0]       dout
);

    logic [DATA_W-1:0] q;
    logic              unused_acc_bits;

    // Taking bits above DROP_W is a floor division by 2^DROP_W followed by
    // a modulo-2^DATA_W wrap.
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= acc[DROP_W +: DATA_W];
    end

    assign unused_acc_bits = ^{acc[DROP_W-1:0], acc[SUM_W-1:DROP_W+DATA_W]};
    assign dout = q;

    p_reset_clear_r3: assert property (@(posedge clk)
        rst |=> (dout == '0));

endmodule

// File: rtl/scm_const_mult.sv
module scm_const_mult #(
    parameter scm_pkg::coef_e COEF    = scm_pkg::COEF_0P7,
    parameter int             DATA_W  = scm_pkg::Q_W,
    parameter int             HEAD_W  = scm_pkg::HEAD_DEF,
    parameter int             GUARD_W = scm_pkg::GUARD_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] x_in,
    output logic [DATA_W-1:0] y_out
);

    localparam int SUM_W  = DATA_W + HEAD_W + GUARD_W;
    localparam int DROP_W = scm_pkg::frac_shift(COEF) + GUARD_W;

    logic signed [SUM_W-1:0] digit_sum;
    logic signed [SUM_W-1:0] series_sum;

    scm_term_sum #(
        .COEF(COEF), .DATA_W(DATA_W), .SUM_W(SUM_W), .GUARD_W(GUARD_W)
    ) u_terms (
        .din(x_in),
        .sum(digit_sum)
    );

    scm_repeat_chain #(
        .COEF(COEF), .SUM_W(SUM_W)
    ) u_series (
        .acc_in(digit_sum),
        .acc_out(series_sum)
    );

    scm_out_reg #(
        .DATA_W(DATA_W), .SUM_W(SUM_W), .DROP_W(DROP_W)
    ) u_out (
        .clk(clk),
        .rst(rst),
        .acc(series_sum),
        .dout(y_out)
    );

    p_zero_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && ($past(x_in) == '0)) |-> (y_out == '0));

    if (COEF == scm_pkg::COEF_X5) begin : g_chk_x5
        p_exact_x5_r6: assert property (@(posedge clk) disable iff (rst)
            $past(!rst) |-> (y_out == DATA_W'($past(x_in) * 5)));
    end else if (COEF == scm_pkg::COEF_0P7) begin : g_chk_07
        p_tol_07_r4: assert property (@(posedge clk) disable iff (rst)
            $past(!rst) |->
            ((longint'($signed(y_out)) * 10 - longint'($signed($past(x_in))) * 7) >= -80));
        p_floor_07_r8: assert property (@(posedge clk) disable iff (rst)
            $past(!rst) |->
            ((longint'($signed(y_out)) * 10 - longint'($signed($past(x_in))) * 7) <= 0));
        p_sign_07_r9: assert property (@(posedge clk) disable iff (rst)
            $past(!rst) |-> (y_out[DATA_W-1] == $past(x_in[DATA_W-1])));
    end else begin : g_chk_001
        p_tol_001_r5: assert property (@(posedge clk) disable iff (rst)
            $past(!rst) |->
            ((longint'($signed(y_out)) * 100 - longint'($signed($past(x_in)))) >= -800));
        p_floor_001_r8: assert property (@(posedge clk) disable iff (rst)
            $past(!rst) |->
            ((longint'($signed(y_out)) * 100 - longint'($signed($past(x_in)))) <= 0));
        p_sign_001_r9: assert property (@(posedge clk) disable iff (rst)
            $past(!rst) |-> (y_out[DATA_W-1] == $past(x_in[DATA_W-1])));
    end

endmodule

// File: tb/scm_const_mult_tb.sv
module scm_const_mult_tb;

    localparam int W = 28;
    localparam int NV = 16;
    localparam logic [W-1:0] VEC [NV] = '{
        28'h0000000, 28'h1000000, 28'h7FFFFFF, 28'h8000000,
        28'hFFFFFFF, 28'h0000001, 28'h0800000, 28'hF000000,
        28'h3333333, 28'hC0FFEE0, 28'h1234567, 28'hABCDEF0,
        28'h5A5A5A5, 28'h000000A, 28'hFFFFF9C, 28'h0000064
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] x_in = '0;
    logic [W-1:0] y_07, y_001, y_x5;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    scm_const_mult #(.COEF(scm_pkg::COEF_0P7)) u_dut (
        .clk(clk), .rst(rst), .x_in(x_in), .y_out(y_07));
    scm_const_mult #(.COEF(scm_pkg::COEF_0P01)) u_dut_c001 (
        .clk(clk), .rst(rst), .x_in(x_in), .y_out(y_001));
    scm_const_mult #(.COEF(scm_pkg::COEF_X5)) u_dut_cx5 (
        .clk(clk), .rst(rst), .x_in(x_in), .y_out(y_x5));

    function automatic longint sx(input logic [W-1:0] v);
        return longint'($signed(v));
    endfunction

    function automatic logic [W-1:0] times5(input logic [W-1:0] v);
        longint p;
        p = sx(v) * 5;
        return p[W-1:0];
    endfunction

    task automatic chk_eq(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    // R4/R5 tolerance, R8 rounding direction, R9 sign for a fractional constant num/den.
    task automatic chk_frac(input string tol_tag, input int num, input int den,
                            input logic [W-1:0] x, input logic [W-1:0] y);
        longint d;
        d = longint'(den) * sx(y) - longint'(num) * sx(x);
        checks++;
        if (d > 8 * den || d < -8 * den) begin
            errors++;
            $display("FAIL %s x=%h got=%0d expected=%0d*%0d/%0d within 8 LSB",
                     tol_tag, x, sx(y), num, sx(x), den);
        end
        checks++;
        if (d > 0 || d <= -2 * den) begin
            errors++;
            $display("FAIL R8 x=%h got=%0d expected floor-like value of %0d*%0d/%0d",
                     x, sx(y), num, sx(x), den);
        end
        checks++;
        if (y[W-1] !== x[W-1]) begin
            errors++;
            $display("FAIL R9 x=%h got sign=%b expected sign=%b", x, y[W-1], x[W-1]);
        end
    endtask

    initial begin : stim
        logic [W-1:0] prev;
        rst  = 1'b1;
        x_in = 28'h1234567;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_eq("R3 reset 0.7", y_07, '0);
        chk_eq("R3 reset 0.01", y_001, '0);
        chk_eq("R3 reset x5", y_x5, '0);

        rst  = 1'b0;
        prev = 28'h1234567;
        for (int k = 0; k < NV; k++) begin
            x_in = VEC[k];
            #1;
            if (k > 0) chk_eq("R2 output held before edge", y_x5, times5(prev));
            @(posedge clk);
            @(negedge clk);
            chk_eq("R6 times five", y_x5, times5(VEC[k]));
            chk_frac("R4", 7, 10, VEC[k], y_07);
            chk_frac("R5", 1, 100, VEC[k], y_001);
            if (VEC[k] == '0) begin
                chk_eq("R7 zero 0.7", y_07, '0);
                chk_eq("R7 zero 0.01", y_001, '0);
                chk_eq("R7 zero x5", y_x5, '0);
            end
            prev = VEC[k];
        end

        // R1: exact integer products confirm a shared binary point.
        x_in = 28'h1000000;
        @(posedge clk);
        @(negedge clk);
        chk_eq("R1 five times one", y_x5, 28'h5000000);
        x_in = 28'h7FFFFFF;
        @(posedge clk);
        @(negedge clk);
        chk_eq("R6 wrap of max", y_x5, 28'h7FFFFFB);
        x_in = 28'h8000000;
        @(posedge clk);
        @(negedge clk);
        chk_eq("R6 wrap of min", y_x5, 28'h8000000);

        // R3: reset in mid-stream clears a nonzero result on the same edge.
        x_in = 28'h7FFFFFF;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk_eq("R3 mid reset 0.7", y_07, '0);
        chk_eq("R3 mid reset x5", y_x5, '0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk_eq("R2 after reset release", y_x5, times5(28'h7FFFFFF));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : watchdog
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog expired got=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule